// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write and read ports run on clocks that have no fixed relation to each other. Pointers cross between the two clock domains in Gray code through synchronizer flops. Each side works out its own occupancy and its own flags from its local pointer and the synchronized copy of the far pointer.

A timing mode is latched while master reset is held. In standard mode, every word is popped with an explicit read strobe. The read-side flag reports "not empty" (high when data is present) and the write-side flag reports "not full" (high while space remains). In fall-through mode, a one-word output register sits after the memory. It fetches the oldest word without being asked, so the read strobe only acknowledges the word that is already shown. In this mode the read-side flag is low while that word is valid, the write-side flag is high only when nothing more can be accepted, and capacity grows by one word.

Two further flags, almost-empty and almost-full (both active low), compare the fill level against offsets that are captured at reset. An offset of zero is replaced by seven. Almost-empty is computed on the read clock and almost-full on the write clock.

Top module: `dmfifo`

## Requirements
- R1: The level of `fwft_sel` while `mrs_n` is low picks the mode (0 = standard, 1 = fall-through). Changing `fwft_sel` after reset is released has no effect until the next reset.
- R2: After reset with no writes: in standard mode `rd_status`=0, `wr_status`=1, `aempty_n`=0, `afull_n`=1. In fall-through mode `rd_status`=1 and `wr_status`=0.
- R3: In standard mode a word leaves only on a read clock edge with `ren_n`=0, and `rdata` shows it after that edge. Words leave in write order. `rd_status` is 1 exactly while words are stored. `ren_n` has no effect while empty.
- R4: In standard mode, `wr_status` goes to 0 once D words are stored. Writes attempted while full are dropped.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `rdata` without any `ren_n` strobe, and `rd_status` goes to 0. Each `ren_n` strobe advances to the next word.
- R6: In fall-through mode the FIFO holds D+1 words. `wr_status` goes to 1 only once D+1 words are stored, and further writes are dropped.
- R7: With stored count s and empty offset n, `aempty_n` is 1 when s > n in standard mode and when s > n+1 in fall-through mode. Otherwise it is 0.
- R8: With full offset m, `afull_n` is 0 when s >= D-m in standard mode and when s >= D+1-m in fall-through mode. Otherwise it is 1.
- R9: When the FIFO is full, the first read clears the full indication: `wr_status` returns to 1 in standard mode and to 0 in fall-through mode.
- R10: An offset input held at zero during reset acts as an offset of 7.
- R11: Data order is kept across the wrap of the storage address and pointer.
- R12: In fall-through mode, once the last word is acknowledged `rd_status` returns to 1. A further `ren_n` strobe leaves `rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write strobe, active low |
| wdata | input | DW | Write data |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read strobe, active low |
| rdata | output | DW | Read data |
| fwft_sel | input | 1 | Mode select, sampled during reset |
| mrs_n | input | 1 | Master reset, active low, asynchronous |
| ae_off | input | AW+1 | Almost-empty offset, captured at reset |
| af_off | input | AW+1 | Almost-full offset, captured at reset |
| rd_status | output | 1 | Standard: not-empty; fall-through: low when output valid |
| wr_status | output | 1 | Standard: not-full; fall-through: high when full |
| aempty_n | output | 1 | Almost-empty, active low |
| afull_n | output | 1 | Almost-full, active low |

## Verification
The bench sweeps every fill level from zero through one word past capacity, in both modes. At each level it settles the flags and compares all four against the arithmetic thresholds, so an off-by-one in the fall-through shift is caught apart from a plain threshold error. Each level is then drained, which checks write order, the wrap of the address, and the clearing of the full indication on the first read. A strobe on an empty FIFO separates a design that ignores the strobe from one that reads anyway. The mode select is flipped after every reset to show that the mode is latched. Runs with zero offsets confirm the substitute value of seven.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FALL = 1'b1
  } fifo_mode_e;

  localparam int DEF_OFFSET = 7;
endpackage

// File: rtl/dmfifo_rstsync.sv
module dmfifo_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dmfifo_gsync.sv
module dmfifo_gsync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dmfifo_wside.sv
module dmfifo_wside
  import dmfifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [AW:0]   af_off,
  input  logic          wen_n,
  input  logic [AW:0]   rgray_s,
  output logic [AW-1:0] waddr,
  output logic          wr_en,
  output logic [AW:0]   wgray,
  output logic          wr_status,
  output logic          afull_n
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e    mode_q;
  logic [CW-1:0] moff_q;
  logic [CW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [CW-1:0] rbin_s, used_d, used_q;
  logic          full_q, full_d, afull_q, afull_d;
  logic          fall;

  // mode and offset load while the local reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= fifo_mode_e'(mode_sel);
      moff_q <= (af_off == '0) ? CW'(DEF_OFFSET) : af_off;
    end
  end

  assign fall = (mode_q == MODE_FALL);

  always_comb begin
    rbin_s  = g2b(rgray_s);
    wr_en   = !wen_n && !full_q;
    bin_d   = bin_q + CW'(wr_en);
    gray_d  = bin_d ^ (bin_d >> 1);
    used_d  = bin_d - rbin_s;
    full_d  = (used_d == CW'(DEPTH));
    afull_d = (({1'b0, used_d} + {1'b0, moff_q}) >= (CW+1)'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      gray_q  <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      full_q  <= full_d;
      afull_q <= afull_d;
    end
  end

  assign waddr     = bin_q[AW-1:0];
  assign wgray     = gray_q;
  assign wr_status = fall ? full_q : !full_q;
  assign afull_n   = !afull_q;

  assign used_q = bin_q - rbin_s;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CW'(DEPTH));
  assert_blocked_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !wen_n) |=> $stable(gray_q));
  assert_gray_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));
endmodule

// File: rtl/dmfifo_rside.sv
module dmfifo_rside
  import dmfifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [AW:0]   ae_off,
  input  logic          ren_n,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rdata,
  output logic          rd_status,
  output logic          aempty_n
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e    mode_q;
  logic [CW-1:0] noff_q;
  logic [CW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [CW-1:0] wbin_s, cnt_d, cnt_q;
  logic [CW:0]   total_d;
  logic          ne_q, ne_d, ov_q, ov_d, above_q, above_d;
  logic          take, fall;
  logic [DW-1:0] dout_q, dout_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= fifo_mode_e'(mode_sel);
      noff_q <= (ae_off == '0) ? CW'(DEF_OFFSET) : ae_off;
    end
  end

  assign fall = (mode_q == MODE_FALL);

  always_comb begin
    wbin_s  = g2b(wgray_s);
    // standard: pop on strobe; fall-through: refill an idle or acknowledged output
    take    = ne_q && (fall ? (!ov_q || !ren_n) : !ren_n);
    bin_d   = bin_q + CW'(take);
    gray_d  = bin_d ^ (bin_d >> 1);
    cnt_d   = wbin_s - bin_d;
    ne_d    = (cnt_d != '0);
    ov_d    = fall && (take || (ov_q && ren_n));
    total_d = {1'b0, cnt_d} + {{CW{1'b0}}, ov_d};
    above_d = total_d > ({1'b0, noff_q} + {{CW{1'b0}}, fall});
    dout_d  = take ? mem_rdata : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      gray_q  <= '0;
      ne_q    <= 1'b0;
      ov_q    <= 1'b0;
      above_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      ne_q    <= ne_d;
      ov_q    <= ov_d;
      above_q <= above_d;
      dout_q  <= dout_d;
    end
  end

  assign raddr     = bin_q[AW-1:0];
  assign rgray     = gray_q;
  assign rdata     = dout_q;
  assign rd_status = fall ? !ov_q : ne_q;
  assign aempty_n  = above_q;

  assign cnt_q = wbin_s - bin_q;

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_std_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !ren_n && ne_q) |=> (bin_q == $past(bin_q) + CW'(1)));
  assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && ne_q && !ov_q) |=> ov_q);
  assert_gray_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));
endmodule

// File: rtl/dmfifo.sv
module dmfifo #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          ren_n,
  output logic [DW-1:0] rdata,
  input  logic          fwft_sel,
  input  logic          mrs_n,
  input  logic [AW:0]   ae_off,
  input  logic [AW:0]   af_off,
  output logic          rd_status,
  output logic          wr_status,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          w_rst_n, r_rst_n;
  logic [CW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_en;
  logic [DW-1:0] mem [DEPTH];

  dmfifo_rstsync #(.STAGES(2)) u_wrst (.clk(wclk), .arst_n(mrs_n), .srst_n(w_rst_n));
  dmfifo_rstsync #(.STAGES(2)) u_rrst (.clk(rclk), .arst_n(mrs_n), .srst_n(r_rst_n));

  dmfifo_gsync #(.W(CW), .STAGES(2)) u_w2r (.clk(rclk), .rst_n(r_rst_n), .d(wgray), .q(wgray_s));
  dmfifo_gsync #(.W(CW), .STAGES(2)) u_r2w (.clk(wclk), .rst_n(w_rst_n), .d(rgray), .q(rgray_s));

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  dmfifo_wside #(.AW(AW)) u_wside (
    .clk(wclk), .rst_n(w_rst_n), .mode_sel(fwft_sel), .af_off(af_off),
    .wen_n(wen_n), .rgray_s(rgray_s), .waddr(waddr), .wr_en(wr_en),
    .wgray(wgray), .wr_status(wr_status), .afull_n(afull_n)
  );

  dmfifo_rside #(.DW(DW), .AW(AW)) u_rside (
    .clk(rclk), .rst_n(r_rst_n), .mode_sel(fwft_sel), .ae_off(ae_off),
    .ren_n(ren_n), .wgray_s(wgray_s), .mem_rdata(mem[raddr]), .raddr(raddr),
    .rgray(rgray), .rdata(rdata), .rd_status(rd_status), .aempty_n(aempty_n)
  );
endmodule

// File: tb/dmfifo_bench.sv
module dmfifo_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int D  = 1 << AW;

  logic          wclk, rclk, wen_n, ren_n, fwft_sel, mrs_n;
  logic [DW-1:0] wdata, rdata;
  logic [AW:0]   ae_off, af_off;
  logic          rd_status, wr_status, aempty_n, afull_n;
  int            nchk, nbad;
  bit            done;

  dmfifo #(.DW(DW), .AW(AW)) u_dmfifo (
    .wclk(wclk), .wen_n(wen_n), .wdata(wdata), .rclk(rclk), .ren_n(ren_n),
    .rdata(rdata), .fwft_sel(fwft_sel), .mrs_n(mrs_n), .ae_off(ae_off),
    .af_off(af_off), .rd_status(rd_status), .wr_status(wr_status),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  initial begin wclk = 1'b0; forever #2ns wclk = ~wclk; end
  initial begin rclk = 1'b0; #0.7ns; forever #2ns rclk = ~rclk; end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode, input int n, input int m);
    mrs_n = 1'b0; fwft_sel = mode; wen_n = 1'b1; ren_n = 1'b1;
    ae_off = (AW+1)'(n); af_off = (AW+1)'(m);
    repeat (4) @(negedge wclk);
    mrs_n = 1'b1;
    repeat (6) @(negedge rclk);
  endtask

  task automatic wr_word(input logic [DW-1:0] v);
    @(negedge wclk); wdata = v; wen_n = 1'b0;
    @(negedge wclk); wen_n = 1'b1;
    repeat (8) @(negedge wclk);
  endtask

  task automatic pulse_ren();
    @(negedge rclk); ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1;
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic run_case(input bit mode, input int n, input int m, input int k, input int base);
    int cap, s, en, em;
    logic [DW-1:0] last;
    cap = mode ? D + 1 : D;
    s   = (k > cap) ? cap : k;
    en  = (n == 0) ? 7 : n;
    em  = (m == 0) ? 7 : m;
    do_reset(mode, n, m);
    fwft_sel = !mode;  // R1: must not change the latched mode
    for (int i = 0; i < k; i++) wr_word(DW'(base + i));
    settle();
    if (mode) begin
      chk((s == 0) ? "R2 rd_status fall" : "R1/R5 rd_status fall", rd_status, (s == 0) ? 1 : 0);
      chk((s == 0) ? "R2 wr_status fall" : "R6 wr_status fall", wr_status, (s == cap) ? 1 : 0);
      chk((n == 0) ? "R10 aempty_n fall" : "R7 aempty_n fall", aempty_n, (s > en + 1) ? 1 : 0);
      chk((m == 0) ? "R10 afull_n fall" : "R8 afull_n fall", afull_n, (s >= D + 1 - em) ? 0 : 1);
    end else begin
      chk((s == 0) ? "R2 rd_status std" : "R1/R3 rd_status std", rd_status, (s > 0) ? 1 : 0);
      chk((s == 0) ? "R2 wr_status std" : "R4 wr_status std", wr_status, (s == D) ? 0 : 1);
      chk((n == 0) ? "R10 aempty_n std" : "R7 aempty_n std", aempty_n, (s > en) ? 1 : 0);
      chk((m == 0) ? "R10 afull_n std" : "R8 afull_n std", afull_n, (s >= D - em) ? 0 : 1);
    end
    for (int i = 0; i < s; i++) begin
      if (mode) begin
        chk((i >= D) ? "R11 wrap data fall" : "R5 fall-through data", rdata, (base + i) & 8'hFF);
        pulse_ren();
        repeat (6) @(negedge rclk);
      end else begin
        pulse_ren();
        chk("R3 read data std", rdata, (base + i) & 8'hFF);
      end
      if (i == 0 && s == cap) begin
        settle();
        chk("R9 full cleared by first read", wr_status, mode ? 0 : 1);
      end
    end
    settle();
    chk(mode ? "R12 drained rd_status" : "R3 drained rd_status", rd_status, mode ? 1 : 0);
    chk("R7 drained aempty_n", aempty_n, 0);
    last = rdata;
    pulse_ren();
    settle();
    chk(mode ? "R12 strobe on empty rdata" : "R3 strobe on empty rdata", rdata, last);
    chk(mode ? "R12 strobe on empty flag" : "R3 strobe on empty flag", rd_status, mode ? 1 : 0);
  endtask

  initial begin
    nchk = 0; nbad = 0; done = 1'b0;
    wdata = '0; wen_n = 1'b1; ren_n = 1'b1; fwft_sel = 1'b0;
    ae_off = '0; af_off = '0; mrs_n = 1'b0;
    for (int md = 0; md < 2; md++) begin
      for (int k = 0; k <= D + 2; k++) run_case(md[0], 2, 2, k, 16 * k + 64 * md + 3);
    end
    run_case(1'b0, 0, 0, 7, 200);
    run_case(1'b0, 0, 0, 8, 210);
    run_case(1'b1, 0, 0, 8, 220);
    run_case(1'b1, 0, 0, 9, 230);
    run_case(1'b1, 3, 1, 6, 100);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog R1..R12 run actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule